// File: doc/BRIEF.md
# Single-Master Bus Memory Slave

This block is a memory target on a single-master AHB-Lite bus. It holds a small word-organised RAM that is cleared by reset. It takes address and control in the address phase of every selected transfer. It then finishes the write or read in the following data phase. The data phases of consecutive transfers overlap with the next address phase, so back-to-back accesses run at one transfer per data phase.

A parameter sets a fixed number of wait states. The slave holds HREADYOUT low for that many cycles before each in-range data phase completes. Accesses whose address lies above the RAM get a two-cycle error response and never touch the storage. Byte and halfword writes change only their own byte lanes. Incrementing bursts of four and eight beats run as ordinary back-to-back transfers. Address decoding, read-data multiplexing and the master sit outside the block. In a single-slave system HREADY is tied to HREADYOUT.

Top module: `ahbm_mem_slave`

## Requirements
- R1: HTRANS is decoded as IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10, SEQ=2'b11. Only a NONSEQ or SEQ transfer sampled with HSEL=1 and HREADY=1 starts an access. IDLE, BUSY and unselected transfers get a zero-wait OKAY data phase and leave the storage unchanged.
- R2: Address and control are registered at the end of the address phase. The matching data phase occupies the following cycle(s), and a read issued right after a write to the same word returns the new value.
- R3: Every in-range data phase holds HREADYOUT low for exactly WAIT_STATES cycles (0 to 3), then drives it high for one completing cycle. While it is low, the pending address on the bus is not taken.
- R4: A write stores HWDATA, sampled in the completing cycle, at the captured address. A later word read of that address returns it on HRDATA in its completing cycle.
- R5: After reset HREADYOUT=1 and HRESP=0, and every storage word reads as zero, including words written before the reset.
- R6: An access at a byte address of MEM_WORDS*4 or above is answered with HRESP=1 and HREADYOUT=0 for one cycle, then HRESP=1 and HREADYOUT=1 for one cycle.
- R7: A write that receives an error response changes no storage word.
- R8: HSIZE=0 writes only byte lane HADDR[1:0]. HSIZE=1 writes lanes 2*HADDR[1] and 2*HADDR[1]+1. HSIZE=2 writes all four lanes. Lane n is HWDATA[8n+7:8n], and the other bytes of the word keep their values.
- R9: Incrementing bursts (HBURST INCR4=3'b011, INCR8=3'b101) are accepted. Each SEQ beat's address is the previous beat address plus 2^HSIZE. Each beat completes with its own wait states, and BUSY cycles may be inserted between beats.
- R10: HRESP is a single bit. It is high only in the two cycles of an error response and low in every other cycle, so no split or retry response is possible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| HSEL | input | 1 | Slave select from the decoder |
| HADDR | input | ADDR_W | Byte address |
| HTRANS | input | 2 | Transfer type |
| HWRITE | input | 1 | 1 = write, 0 = read |
| HSIZE | input | 3 | Transfer size, log2 of bytes |
| HBURST | input | 3 | Burst type |
| HMASTLOCK | input | 1 | Locked sequence flag |
| HWDATA | input | DATA_W | Write data, valid in the data phase |
| HREADY | input | 1 | Bus-wide ready, previous transfer done |
| HREADYOUT | output | 1 | Slave ready, low to insert a wait state |
| HRESP | output | 1 | 0 = OKAY, 1 = ERROR |
| HRDATA | output | DATA_W | Read data, valid in the completing cycle |

## Verification
The bench aims at the edges of the pipeline.

- A read placed right behind a write to the same word would return the old word if storage were updated a cycle late.
- An address held during a stall would be taken twice if capture ignored HREADY.
- An errored write aimed at an address that aliases word 0 exposes a design that forgets to block the write enable.
- A byte write followed by a halfword write shows any lane decode that spills onto neighbouring bytes.
- A reset issued after words have been written catches storage that is not cleared.
- Bursts with an inserted BUSY beat catch a design that treats BUSY as an access or drops a beat's wait states.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'b000,
        BU_INCR   = 3'b001,
        BU_WRAP4  = 3'b010,
        BU_INCR4  = 3'b011,
        BU_WRAP8  = 3'b100,
        BU_INCR8  = 3'b101,
        BU_WRAP16 = 3'b110,
        BU_INCR16 = 3'b111
    } burst_e;

    typedef enum logic {
        RSP_OKAY  = 1'b0,
        RSP_ERROR = 1'b1
    } resp_e;

    // A lane belongs to the access when it falls in the same naturally
    // aligned group of 2^size bytes as the low address bits.
    function automatic logic lane_hit(int unsigned lane, logic [2:0] size,
                                      int unsigned lo);
        return (lane >> size) == (lo >> size);
    endfunction

endpackage

// File: rtl/ahbm_phase_ctrl.sv
module ahbm_phase_ctrl
    import ahbm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 6,
    parameter int LO_W        = 2,
    parameter int WAIT_STATES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsel,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [ADDR_W-1:0] haddr,
    output logic              hreadyout,
    output logic              hresp,
    output logic              dp_valid,
    output logic              dp_err,
    output logic              dp_write,
    output logic [IDX_W-1:0]  dp_idx,
    output logic [LO_W-1:0]   dp_lo,
    output logic [2:0]        dp_size
);

    localparam int BYTE_AW = IDX_W + LO_W;
    localparam int WAIT_W  = (WAIT_STATES > 1) ? $clog2(WAIT_STATES + 1) : 1;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic             write;
        logic [IDX_W-1:0] idx;
        logic [LO_W-1:0]  lo;
        logic [2:0]       size;
    } dphase_t;

    dphase_t          dp_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic             errph_q;
    trans_e           tr;
    logic             take;
    logic             out_of_range;

    assign tr           = trans_e'(htrans);
    assign take         = hsel && hready && (tr == TR_NSEQ || tr == TR_SEQ);
    assign out_of_range = |haddr[ADDR_W-1:BYTE_AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q    <= '0;
            wcnt_q  <= '0;
            errph_q <= 1'b0;
        end else if (hready) begin
            dp_q.valid <= take;
            dp_q.err   <= take && out_of_range;
            dp_q.write <= hwrite;
            dp_q.idx   <= haddr[LO_W +: IDX_W];
            dp_q.lo    <= haddr[LO_W-1:0];
            dp_q.size  <= hsize;
            wcnt_q     <= WAIT_W'(WAIT_STATES);
            errph_q    <= 1'b0;
        end else if (dp_q.valid && !hreadyout) begin
            if (dp_q.err) begin
                errph_q <= 1'b1;
            end else begin
                wcnt_q <= wcnt_q - WAIT_W'(1);
            end
        end
    end

    always_comb begin
        if (!dp_q.valid) begin
            hreadyout = 1'b1;
        end else if (dp_q.err) begin
            hreadyout = errph_q;
        end else begin
            hreadyout = (wcnt_q == '0);
        end
    end

    assign hresp    = (dp_q.valid && dp_q.err) ? RSP_ERROR : RSP_OKAY;
    assign dp_valid = dp_q.valid;
    assign dp_err   = dp_q.err;
    assign dp_write = dp_q.write;
    assign dp_idx   = dp_q.idx;
    assign dp_lo    = dp_q.lo;
    assign dp_size  = dp_q.size;

    // R6
    err_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    // R10
    resp_only_err_chk: assert property (@(posedge clk) disable iff (rst)
        hresp |-> $past(hresp) || !hreadyout);

endmodule

// File: rtl/ahbm_lane_mask.sv
module ahbm_lane_mask
    import ahbm_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LO_W  = 2
) (
    input  logic [2:0]       size,
    input  logic [LO_W-1:0]  lo,
    output logic [LANES-1:0] strb
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign strb[g] = lane_hit(32'(g), size, 32'(lo));
    end

endmodule

// File: rtl/ahbm_store.sv
module ahbm_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 64,
    parameter int IDX_W  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [DATA_W/8-1:0] strb,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (we) begin
            for (int b = 0; b < LANES; b++) begin
                if (strb[b]) begin
                    mem[idx][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/ahbm_mem_slave.sv
module ahbm_mem_slave
    import ahbm_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MEM_WORDS   = 64,
    parameter int WAIT_STATES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              HSEL,
    input  logic [ADDR_W-1:0] HADDR,
    input  logic [1:0]        HTRANS,
    input  logic              HWRITE,
    input  logic [2:0]        HSIZE,
    input  logic [2:0]        HBURST,
    input  logic              HMASTLOCK,
    input  logic [DATA_W-1:0] HWDATA,
    input  logic              HREADY,
    output logic              HREADYOUT,
    output logic              HRESP,
    output logic [DATA_W-1:0] HRDATA
);

    localparam int LANES = DATA_W / 8;
    localparam int LO_W  = $clog2(LANES);
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic             dp_valid, dp_err, dp_write;
    logic [IDX_W-1:0] dp_idx;
    logic [LO_W-1:0]  dp_lo;
    logic [2:0]       dp_size;
    logic [LANES-1:0] strb;
    logic [DATA_W-1:0] rd_word;
    logic             mem_we;

    ahbm_phase_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_W(LO_W), .WAIT_STATES(WAIT_STATES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .hsel(HSEL), .hready(HREADY), .htrans(HTRANS),
        .hwrite(HWRITE), .hsize(HSIZE), .haddr(HADDR),
        .hreadyout(HREADYOUT), .hresp(HRESP), .dp_valid(dp_valid),
        .dp_err(dp_err), .dp_write(dp_write), .dp_idx(dp_idx),
        .dp_lo(dp_lo), .dp_size(dp_size)
    );

    ahbm_lane_mask #(.LANES(LANES), .LO_W(LO_W)) u_mask (
        .size(dp_size), .lo(dp_lo), .strb(strb)
    );

    assign mem_we = dp_valid && !dp_err && dp_write && HREADYOUT;

    ahbm_store #(.DATA_W(DATA_W), .WORDS(MEM_WORDS), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst), .we(mem_we), .strb(strb), .idx(dp_idx),
        .wdata(HWDATA), .rdata(rd_word)
    );

    assign HRDATA = (dp_valid && !dp_err && !dp_write) ? rd_word : '0;

    // Protocol tracking used by the checks below.
    logic              prev_ok;
    logic [ADDR_W-1:0] prev_addr;
    logic [2:0]        prev_size;
    logic [2:0]        prev_burst;
    logic              prev_lock;
    logic [2:0]        low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ok    <= 1'b0;
            prev_addr  <= '0;
            prev_size  <= '0;
            prev_burst <= '0;
            prev_lock  <= 1'b0;
        end else if (HSEL && HREADY && HTRANS[1]) begin
            prev_ok    <= 1'b1;
            prev_addr  <= HADDR;
            prev_size  <= HSIZE;
            prev_burst <= HBURST;
            prev_lock  <= HMASTLOCK;
        end else if (HSEL && HREADY && HTRANS == TR_IDLE) begin
            prev_ok <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
        end else if (dp_valid && !dp_err && !HREADYOUT) begin
            if (low_run != 3'd7) low_run <= low_run + 3'd1;
        end else begin
            low_run <= '0;
        end
    end

    // R1
    idle_zero_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (HSEL && HREADY && !HTRANS[1]) |=> (HREADYOUT && !HRESP));

    // R3
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        32'(low_run) <= WAIT_STATES);

    // R5
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (HREADYOUT && !HRESP));

    // R7
    no_err_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !HRESP);

    // R9
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (HSEL && HREADY && HTRANS == TR_SEQ && prev_ok) |->
        (HADDR == prev_addr + (ADDR_W'(1) << prev_size)) &&
        (HBURST == prev_burst) && (HMASTLOCK == prev_lock));

endmodule

// File: tb/tb_ahbm_mem_slave.sv
module tb_ahbm_mem_slave;

    localparam int CLK_PERIOD = 10;
    localparam int WS         = 2;
    localparam int WORDS      = 64;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        bit          sel;
        bit [1:0]    tr;
        bit          wr;
        logic [31:0] addr;
        bit [2:0]    size;
        bit [2:0]    burst;
        logic [31:0] wdata;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic        HSEL = 1'b0;
    logic [31:0] HADDR = '0;
    logic [1:0]  HTRANS = 2'b00;
    logic        HWRITE = 1'b0;
    logic [2:0]  HSIZE = 3'd0;
    logic [2:0]  HBURST = 3'd0;
    logic        HMASTLOCK = 1'b0;
    logic [31:0] HWDATA = '0;
    logic        HREADY;
    logic        HREADYOUT, HRESP;
    logic [31:0] HRDATA;

    assign HREADY = HREADYOUT;
    always #(CLK_PERIOD/2) clk = ~clk;

    ahbm_mem_slave #(
        .ADDR_W(32), .DATA_W(32), .MEM_WORDS(WORDS), .WAIT_STATES(WS)
    ) dut (
        .clk(clk), .rst(rst), .HSEL(HSEL), .HADDR(HADDR), .HTRANS(HTRANS),
        .HWRITE(HWRITE), .HSIZE(HSIZE), .HBURST(HBURST), .HMASTLOCK(HMASTLOCK),
        .HWDATA(HWDATA), .HREADY(HREADY), .HREADYOUT(HREADYOUT),
        .HRESP(HRESP), .HRDATA(HRDATA)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model state
    logic [31:0] mm [WORDS];
    item_t q[$];
    item_t cur;
    bit    cur_taken;
    bit    m_valid, m_err, m_write, m_errph;
    logic [31:0] m_addr, m_wdata;
    bit [2:0] m_size;
    int    m_wcnt;
    string m_tag;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    function automatic item_t mk(bit sel, bit [1:0] tr, bit wr, logic [31:0] a,
                                 bit [2:0] sz, bit [2:0] bu, logic [31:0] d, string tag);
        item_t it;
        it.sel = sel; it.tr = tr; it.wr = wr; it.addr = a;
        it.size = sz; it.burst = bu; it.wdata = d; it.tag = tag;
        return it;
    endfunction

    function automatic item_t idle_item();
        return mk(1'b0, 2'b00, 1'b0, 32'h0, 3'd0, 3'd0, 32'h0, "R1");
    endfunction

    task automatic push_burst(bit wr, logic [31:0] base, bit [2:0] sz, int beats,
                              bit [2:0] bu, logic [31:0] d0, string tag);
        for (int i = 0; i < beats; i++) begin
            q.push_back(mk(1'b1, (i == 0) ? 2'b10 : 2'b11, wr,
                           base + (32'(i) << sz), sz, bu,
                           d0 + 32'(i) * 32'h01010101, tag));
        end
    endtask

    task automatic model_clear();
        for (int w = 0; w < WORDS; w++) mm[w] = '0;
        m_valid = 0; m_err = 0; m_write = 0; m_errph = 0;
        m_addr = '0; m_wdata = '0; m_size = 0; m_wcnt = 0; m_tag = "R5";
        cur = idle_item();
        cur_taken = 1;
    endtask

    task automatic drive_bus();
        HSEL   = cur.sel;   HTRANS = cur.tr;    HWRITE = cur.wr;
        HADDR  = cur.addr;  HSIZE  = cur.size;  HBURST = cur.burst;
        HWDATA = m_wdata;
    endtask

    task automatic apply_write();
        int idx, lo, b;
        idx = int'((m_addr >> 2) % WORDS);
        lo  = int'(m_addr[1:0]);
        case (m_size)
            3'd0: mm[idx][8*lo +: 8] = m_wdata[8*lo +: 8];
            3'd1: begin
                b = lo & 2;
                mm[idx][8*b +: 16] = m_wdata[8*b +: 16];
            end
            default: mm[idx] = m_wdata;
        endcase
    endtask

    // One bus cycle: compare outputs, drive inputs, advance the model.
    task automatic step();
        bit exp_rdy, exp_resp;
        logic [31:0] exp_rd;
        @(negedge clk);
        exp_rdy  = !m_valid || (m_err ? m_errph : (m_wcnt == 0));
        exp_resp = m_valid && m_err;
        chk(HREADYOUT === exp_rdy, m_valid ? (m_err ? "R6" : "R3") : "R1",
            "HREADYOUT", 32'(HREADYOUT), 32'(exp_rdy));
        chk(HRESP === exp_resp, m_err ? "R6" : "R10", "HRESP",
            32'(HRESP), 32'(exp_resp));
        if (exp_rdy && m_valid && !m_err && !m_write) begin
            exp_rd = mm[(m_addr >> 2) % WORDS];
            chk(HRDATA === exp_rd, m_tag, "HRDATA", HRDATA, exp_rd);
        end
        if (cur_taken) begin
            cur = (q.size() > 0) ? q.pop_front() : idle_item();
        end
        drive_bus();
        if (exp_rdy) begin
            if (m_valid && !m_err && m_write) apply_write();
            m_valid   = cur.sel && cur.tr[1];
            m_err     = m_valid && (cur.addr >= 32'(WORDS * 4));
            m_write   = cur.wr;
            m_addr    = cur.addr;
            m_size    = cur.size;
            m_wdata   = cur.wdata;
            m_tag     = cur.tag;
            m_wcnt    = WS;
            m_errph   = 0;
            cur_taken = 1;
        end else begin
            cur_taken = 0;
            if (m_err) m_errph = 1;
            else m_wcnt--;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        model_clear();
        drive_bus();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R5: outputs straight after reset
        chk(HREADYOUT === 1'b1, "R5", "HREADYOUT after reset", 32'(HREADYOUT), 32'h1);
        chk(HRESP === 1'b0, "R5", "HRESP after reset", 32'(HRESP), 32'h0);
    endtask

    task automatic run_queue();
        while (q.size() > 0 || !cur_taken || m_valid) step();
        repeat (2) step();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        fails++;
        $display("FAIL R3 watchdog: actual %0d cycles expected completion", WATCHDOG);
        finish_run();
    end

    initial begin
        do_reset();

        // R5: unwritten words read zero
        q.push_back(mk(1, 2'b10, 0, 32'h10, 3'd2, 3'd0, 0, "R5"));
        q.push_back(mk(1, 2'b10, 0, 32'h24, 3'd2, 3'd0, 0, "R5"));
        // R2 / R4: write then immediate read of the same word
        q.push_back(mk(1, 2'b10, 1, 32'h00, 3'd2, 3'd0, 32'hA5A51234, "R4"));
        q.push_back(mk(1, 2'b10, 0, 32'h00, 3'd2, 3'd0, 0, "R2"));
        q.push_back(mk(1, 2'b10, 1, 32'h3C, 3'd2, 3'd0, 32'hDEADBEEF, "R4"));
        q.push_back(idle_item());
        q.push_back(mk(1, 2'b10, 0, 32'h3C, 3'd2, 3'd0, 0, "R4"));
        // R8: byte then halfword lanes
        q.push_back(mk(1, 2'b10, 1, 32'h40, 3'd2, 3'd0, 32'h11223344, "R8"));
        q.push_back(mk(1, 2'b10, 1, 32'h41, 3'd0, 3'd0, 32'hAABBCCDD, "R8"));
        q.push_back(mk(1, 2'b10, 0, 32'h40, 3'd2, 3'd0, 0, "R8"));
        q.push_back(mk(1, 2'b10, 1, 32'h42, 3'd1, 3'd0, 32'h55667788, "R8"));
        q.push_back(mk(1, 2'b10, 0, 32'h40, 3'd2, 3'd0, 0, "R8"));
        q.push_back(mk(1, 2'b10, 1, 32'h44, 3'd1, 3'd0, 32'h99AA0F0E, "R8"));
        q.push_back(mk(1, 2'b10, 0, 32'h44, 3'd2, 3'd0, 0, "R8"));
        // R1: unselected, BUSY and IDLE writes have no effect on word 0
        q.push_back(mk(0, 2'b10, 1, 32'h00, 3'd2, 3'd0, 32'h0BADF00D, "R1"));
        q.push_back(mk(1, 2'b01, 1, 32'h00, 3'd2, 3'd0, 32'h0BADF00D, "R1"));
        q.push_back(mk(1, 2'b00, 1, 32'h00, 3'd2, 3'd0, 32'h0BADF00D, "R1"));
        q.push_back(mk(1, 2'b10, 0, 32'h00, 3'd2, 3'd0, 0, "R1"));
        // R6 / R7: out-of-range write aliasing word 0, out-of-range read
        q.push_back(mk(1, 2'b10, 1, 32'h100, 3'd2, 3'd0, 32'hFFFF0000, "R7"));
        q.push_back(mk(1, 2'b10, 0, 32'h1FC, 3'd2, 3'd0, 0, "R6"));
        q.push_back(mk(1, 2'b10, 0, 32'h00, 3'd2, 3'd0, 0, "R7"));
        // R9: bursts, one with a BUSY beat
        push_burst(1, 32'h80, 3'd2, 4, 3'b011, 32'h10203040, "R9");
        push_burst(0, 32'h80, 3'd2, 4, 3'b011, 32'h0, "R9");
        push_burst(1, 32'hA0, 3'd2, 8, 3'b101, 32'h01000001, "R9");
        push_burst(0, 32'hA0, 3'd2, 8, 3'b101, 32'h0, "R9");
        q.push_back(mk(1, 2'b10, 1, 32'hC0, 3'd1, 3'b011, 32'h00001111, "R9"));
        q.push_back(mk(1, 2'b11, 1, 32'hC2, 3'd1, 3'b011, 32'h22220000, "R9"));
        q.push_back(mk(1, 2'b01, 1, 32'hC4, 3'd1, 3'b011, 32'h0, "R1"));
        q.push_back(mk(1, 2'b11, 1, 32'hC4, 3'd1, 3'b011, 32'h00003333, "R9"));
        q.push_back(mk(1, 2'b11, 1, 32'hC6, 3'd1, 3'b011, 32'h44440000, "R9"));
        q.push_back(mk(1, 2'b10, 0, 32'hC0, 3'd2, 3'd0, 0, "R9"));
        q.push_back(mk(1, 2'b10, 0, 32'hC4, 3'd2, 3'd0, 0, "R9"));
        run_queue();

        // R5: a second reset clears written words
        do_reset();
        q.push_back(mk(1, 2'b10, 0, 32'h00, 3'd2, 3'd0, 0, "R5"));
        q.push_back(mk(1, 2'b10, 0, 32'h80, 3'd2, 3'd0, 0, "R5"));
        q.push_back(mk(1, 2'b10, 0, 32'h40, 3'd2, 3'd0, 0, "R5"));
        run_queue();

        finish_run();
    end

endmodule